// File: doc/BRIEF.md
# Serial Sample Output Framer

The framer sends 32-bit output words, each holding address, status and conversion data, over a three-line serial link: a serial clock, a data line and a frame line. A fourth output gives a half-word marker. The serial clock comes from the block's own clock. Each bit period lasts two or four `clk` cycles, chosen by two rate pins. The clock idles when no word is in flight. A producer pulses `word_vld` with a word on `word_in`. If the framer is idle, the word starts at once. If a transfer is already running, the word is held and sent directly after that transfer.

In SPI-style signalling, the frame line is an active-low frame sync that covers the 32 bit periods of a word. In I2S-style signalling, the same three lines become SD, SCK and WS. WS then marks the two 16-bit halves of the word, and each half's MSB trails its WS edge by one SCK period. A polarity input inverts the serial clock for receivers that capture on the opposite edge.

Top module: `ser_word_framer`

## Requirements
- R1: During and after reset, with no word pending, `sck_o` equals `sclk_inv`, `frame_o` is 1, and `half_o` and `sd_o` are 0.
- R2: In SPI mode (`i2s_mode`=0 at frame start), a word occupies exactly 32 bit periods. `frame_o` is 0 in each of them, and `sd_o` carries the word MSB first (bit 31 in the first period).
- R3: Let the raw clock be `sck_o` XOR `sclk_inv`. The data line changes only together with a raw-clock rising edge and holds its value until the following raw falling edge.
- R4: With `sclk_inv`=1, every level of `sck_o` is inverted relative to `sclk_inv`=0, both while idle and during transfers.
- R5: If `rate_sel0` equals `rate_sel1`, the raw clock is high for 1 `clk` cycle and low for 1 per bit. If they differ, it is high for 2 and low for 2.
- R6: `half_o` is 1 for the whole 16th and the whole 32nd data bit period of each word, and 0 otherwise.
- R7: A `word_vld` pulse while idle starts a frame on the next clock edge. A pulse during a transfer is held and sent with no gap after the current word. If several pulses arrive during one transfer, only the last held word is sent.
- R8: In I2S mode, a frame started from idle begins with one lead period in which `sd_o`=0 and `frame_o`=0. A frame chained directly to a previous one has no lead period. During data bit k (k=0..31, counted from the MSB), `frame_o` = bit 4 of (k+1): it is 0 for k 0..14, 1 for k 15..30, and 0 for k 31.
- R9: Mode and rate are sampled at frame start. Changing `rate_sel0`/`rate_sel1` during a frame does not alter that frame's bit period.
- R10: After the last bit of a word, with no word held, the framer returns to the idle levels of R1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock; the serial clock is derived from it |
| rst_n | input | 1 | Asynchronous active-low reset |
| word_vld | input | 1 | One-cycle strobe: a new word is present |
| word_in | input | 32 | Word to send (address, status, data) |
| sclk_inv | input | 1 | Serial clock polarity select |
| rate_sel0 | input | 1 | Rate select, first pin |
| rate_sel1 | input | 1 | Rate select, second pin |
| i2s_mode | input | 1 | 0: SPI-style framing, 1: I2S-style |
| sck_o | output | 1 | Serial clock (SCK in I2S mode) |
| sd_o | output | 1 | Serial data (SD in I2S mode) |
| frame_o | output | 1 | Active-low frame sync, or WS in I2S mode |
| half_o | output | 1 | Half-word latch pulse |

## Verification
The bench rebuilds every transmitted slot from the raw clock's falling edges. It checks each slot's data bit, frame-line level, latch level and high time against slot lists that it computes from the words sent.

- Isolated words in both modes, with both polarities and all four rate-pin combinations, tell the lead period apart from its absence. They also tell the two rate settings and the two polarities apart.
- Back-to-back words, and a triple strobe in which the middle word must vanish, separate correct holding from dropping or queuing.
- A rate flip in the middle of a frame shows whether the rate is latched at frame start.
- Random words with alternating bit patterns expose shift-order and off-by-one errors at the 16-bit boundary.

// File: rtl/ser_word_framer.sv
module ser_word_framer #(
  parameter int WORD_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              word_vld,
  input  logic [WORD_W-1:0] word_in,
  input  logic              sclk_inv,
  input  logic              rate_sel0,
  input  logic              rate_sel1,
  input  logic              i2s_mode,
  output logic              sck_o,
  output logic              sd_o,
  output logic              frame_o,
  output logic              half_o
);
  localparam int CW = $clog2(WORD_W);
  localparam int HW = CW - 1;
  localparam logic [CW-1:0] LAST_IDX = CW'(WORD_W - 1);
  localparam logic [CW:0]   TWO = (CW + 1)'(2);

  logic              busy, raw, fl, lead, slow_q, i2s_q, pend_v;
  logic [WORD_W-1:0] sh, pend_w;
  logic [CW-1:0]     bitcnt;
  logic [1:0]        ph;

  wire [1:0]  ph_mid    = slow_q ? 2'd1 : 2'd0;
  wire [1:0]  ph_end    = slow_q ? 2'd3 : 2'd1;
  wire        slot_end  = busy && (ph == ph_end);
  wire        frame_end = slot_end && !lead && (bitcnt == LAST_IDX);
  wire        go        = (word_vld && !busy) || (frame_end && (word_vld || pend_v));
  wire [WORD_W-1:0] go_word = word_vld ? word_in : pend_w;
  wire [CW:0] k_plus2   = {1'b0, bitcnt} + TWO;

  assign sck_o   = raw ^ sclk_inv;
  assign sd_o    = busy & ~lead & sh[WORD_W-1];
  assign frame_o = fl;
  assign half_o  = busy & ~lead & (&bitcnt[HW-1:0]);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_v <= 1'b0;
      pend_w <= '0;
    end else if (busy && !frame_end && word_vld) begin
      pend_v <= 1'b1;
      pend_w <= word_in;
    end else if (frame_end) begin
      pend_v <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy   <= 1'b0;
      raw    <= 1'b0;
      fl     <= 1'b1;
      lead   <= 1'b0;
      slow_q <= 1'b0;
      i2s_q  <= 1'b0;
      sh     <= '0;
      bitcnt <= '0;
      ph     <= 2'd0;
    end else if (go) begin
      busy   <= 1'b1;
      raw    <= 1'b1;
      fl     <= 1'b0;
      lead   <= i2s_mode & fl;
      slow_q <= rate_sel0 ^ rate_sel1;
      i2s_q  <= i2s_mode;
      sh     <= go_word;
      bitcnt <= '0;
      ph     <= 2'd0;
    end else if (busy) begin
      if (ph == ph_mid) begin
        raw <= 1'b0;
        ph  <= ph + 2'd1;
      end else if (ph == ph_end) begin
        ph  <= 2'd0;
        raw <= 1'b1;
        if (lead) begin
          lead <= 1'b0;
        end else if (bitcnt == LAST_IDX) begin
          busy <= 1'b0;
          raw  <= 1'b0;
          fl   <= 1'b1;
        end else begin
          bitcnt <= bitcnt + 1'b1;
          sh     <= {sh[WORD_W-2:0], 1'b0};
          fl     <= i2s_q & k_plus2[HW];
        end
      end else begin
        ph <= ph + 2'd1;
      end
    end
  end

  p_idle_levels_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (fl && !raw && !pend_v));

  p_spi_frame_low_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !i2s_q) |-> !frame_o);

  p_bit_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (slot_end && !lead && bitcnt != LAST_IDX) |=> (bitcnt == $past(bitcnt) + 1'b1));

  p_data_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !$rose(raw) && $past(busy)) |-> $stable(sh));

  p_rise_at_slot_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(raw) |-> (ph == 2'd0));

  p_latch_in_frame_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (half_o && !i2s_q) |-> !frame_o);

  p_pend_only_busy_r7: assert property (@(posedge clk) disable iff (!rst_n)
    pend_v |-> busy);

  p_rate_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !go) |=> $stable(slow_q));
endmodule

// File: tb/ser_word_framer_tb.sv
module ser_word_framer_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        word_vld = 1'b0;
  logic [31:0] word_in = '0;
  logic        sclk_inv = 1'b0;
  logic        rate_sel0 = 1'b0;
  logic        rate_sel1 = 1'b0;
  logic        i2s_mode = 1'b0;
  logic        sck_o, sd_o, frame_o, half_o;

  int vectors = 0;
  int fails = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  ser_word_framer #(.WORD_W(32)) u_dut (
    .clk(clk), .rst_n(rst_n), .word_vld(word_vld), .word_in(word_in),
    .sclk_inv(sclk_inv), .rate_sel0(rate_sel0), .rate_sel1(rate_sel1),
    .i2s_mode(i2s_mode), .sck_o(sck_o), .sd_o(sd_o), .frame_o(frame_o),
    .half_o(half_o)
  );

  bit rec_d [0:255];
  bit rec_dr[0:255];
  bit rec_fl[0:255];
  bit rec_lt[0:255];
  int rec_hi[0:255];
  int rec_n = 0;
  bit exp_d [0:255];
  bit exp_fl[0:255];
  bit exp_lt[0:255];
  int exp_n = 0;
  bit rec_on = 0;
  bit raw_prev = 0;
  bit d_rise = 0;
  int hi_cnt = 0;

  always @(negedge clk) begin
    bit raw_now;
    raw_now = sck_o ^ sclk_inv;
    if (raw_now) hi_cnt++;
    if (raw_now && !raw_prev) d_rise = sd_o;
    if (!raw_now && raw_prev && rec_on && rec_n < 256) begin
      rec_d[rec_n]  = sd_o;
      rec_dr[rec_n] = d_rise;
      rec_fl[rec_n] = frame_o;
      rec_lt[rec_n] = half_o;
      rec_hi[rec_n] = hi_cnt;
      rec_n++;
    end
    if (!raw_now) hi_cnt = 0;
    raw_prev = raw_now;
  end

  function automatic bit ws_of(input int k);
    return ((k + 1) >> 4) & 1;
  endfunction

  task automatic add_frame(input logic [31:0] w, input bit i2s, input bit lead);
    if (lead) begin
      exp_d[exp_n] = 0; exp_fl[exp_n] = 0; exp_lt[exp_n] = 0; exp_n++;
    end
    for (int k = 0; k < 32; k++) begin
      exp_d[exp_n]  = w[31-k];
      exp_fl[exp_n] = i2s ? ws_of(k) : 1'b0;
      exp_lt[exp_n] = (k % 16) == 15;
      exp_n++;
    end
  endtask

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    vectors++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(posedge clk);
  endtask

  task automatic strobe(input logic [31:0] w);
    @(posedge clk); #1;
    word_vld = 1'b1; word_in = w;
    @(posedge clk); #1;
    word_vld = 1'b0;
  endtask

  task automatic idle_check(input string tag);
    @(negedge clk);
    chk(sck_o == sclk_inv, {tag, " R4 idle sck"}, sck_o, sclk_inv);
    chk(frame_o == 1'b1, {tag, " frame idle"}, frame_o, 1);
    chk(half_o == 1'b0, {tag, " latch idle"}, half_o, 0);
    chk(sd_o == 1'b0, {tag, " data idle"}, sd_o, 0);
  endtask

  task automatic compare(input int h, input bit i2s, input string tag);
    int n;
    chk(rec_n == exp_n, {tag, " R2 slot count"}, rec_n, exp_n);
    n = (rec_n < exp_n) ? rec_n : exp_n;
    for (int i = 0; i < n; i++) begin
      chk(rec_d[i] == exp_d[i], {tag, " R2 data bit"}, rec_d[i], exp_d[i]);
      chk(rec_dr[i] == rec_d[i], {tag, " R3 data stable"}, rec_dr[i], rec_d[i]);
      chk(rec_fl[i] == exp_fl[i], {tag, i2s ? " R8 ws" : " R2 frame"}, rec_fl[i], exp_fl[i]);
      chk(rec_lt[i] == exp_lt[i], {tag, " R6 latch"}, rec_lt[i], exp_lt[i]);
      chk(rec_hi[i] == h, {tag, " R5 high time"}, rec_hi[i], h);
    end
  endtask

  // mode: 0 = separate frames, 1 = chained, 2 = triple strobe (middle dropped)
  task automatic scen(input logic [31:0] w0, input logic [31:0] w1, input logic [31:0] w2,
                      input int mode, input bit i2s, input bit ra, input bit rb,
                      input bit pol, input bit flip, input string tag);
    int h;
    @(posedge clk); #1;
    i2s_mode = i2s; rate_sel0 = ra; rate_sel1 = rb; sclk_inv = pol;
    cyc(3);
    h = (ra ^ rb) ? 2 : 1;
    rec_n = 0; exp_n = 0; rec_on = 1;
    if (mode == 0) begin
      strobe(w0);
      if (flip) begin
        cyc(10); #1; rate_sel0 = ~ra;
      end
      cyc(150);
      if (flip) begin
        #1; rate_sel0 = ra;
      end
      add_frame(w0, i2s, i2s);
      if (!flip) begin
        strobe(w1); cyc(150);
        add_frame(w1, i2s, i2s);
      end
    end else begin
      strobe(w0);
      cyc(4);
      strobe(w1);
      if (mode == 2) begin
        cyc(4); strobe(w2);
      end
      cyc(300);
      add_frame(w0, i2s, i2s);
      add_frame(mode == 2 ? w2 : w1, i2s, 1'b0);
    end
    rec_on = 0;
    compare(h, i2s, tag);
    idle_check({tag, " R10"});
  endtask

  initial begin
    int seed;
    seed = $urandom(32'h5eed);
    cyc(2);
    @(negedge clk);
    chk(sck_o == 1'b0, "R1 reset sck", sck_o, 0);
    chk(frame_o == 1'b1, "R1 reset frame", frame_o, 1);
    chk(half_o == 1'b0, "R1 reset latch", half_o, 0);
    chk(sd_o == 1'b0, "R1 reset data", sd_o, 0);
    @(posedge clk); #1; rst_n = 1'b1;
    idle_check("R1 after reset");

    scen(32'h8000_0001, 32'hA5A5_5A5A, 0, 0, 0, 0, 0, 0, 0, "R2 spi fast");
    scen(32'hFFFF_0000, 32'h0000_FFFF, 0, 0, 0, 1, 0, 0, 0, "R5 spi slow");
    scen(32'h1234_5678, 32'h8765_4321, 0, 0, 0, 1, 1, 1, 0, "R4 spi inverted");
    scen(32'hC001_8003, 32'h7FFE_FFFE, 0, 0, 1, 0, 1, 0, 0, "R8 i2s isolated");
    scen(32'hDEAD_BEEF, 32'h0F0F_F0F0, 0, 1, 0, 0, 0, 1, 0, "R7 spi chained");
    scen(32'h1111_2222, 32'h3333_4444, 0, 1, 1, 1, 0, 0, 0, "R7 R8 i2s chained");
    scen(32'hAAAA_AAAA, 32'h5555_5555, 32'hF00D_CAFE, 2, 0, 0, 0, 0, 0, "R7 last held wins");
    scen(32'h0180_0F0F, 0, 0, 0, 0, 0, 0, 0, 1, "R9 rate flip mid frame");
    scen(32'h0180_0F0F, 0, 0, 0, 1, 1, 0, 1, 1, "R9 rate flip i2s");

    for (int it = 0; it < 24; it++) begin
      logic [31:0] a, b;
      int m;
      a = $urandom; b = $urandom;
      m = $urandom_range(0, 1);
      scen(a, b, 0, m, 1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)),
           1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)), 0, "random");
    end

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end
endmodule